// File: doc/BRIEF.md
# Four-Stage Cipher Round Pipeline

This block is the arithmetic core of a small sequenced cipher engine. A 16-bit word moves through four registered stages: a modulo-2^16 adder, an XOR unit, a nibble-wise substitution layer and a rotate-XOR diffusion layer. The two operands come from the two read ports of an external dual-port register file. The final stage register drives the value written back through that file's second port.

Three control bits come with every instruction. Each bit steers its own stage in the same cycle it is presented, whatever word that stage holds at the time. This way one instruction can start a new addition in stage 0 while it also decides how an older word is mixed in stage 1 and finished in stage 3.

There is no sequencer. The pipeline is a fixed chain, and the only states are the contents of the four stage registers: ADD, MIX, SUB and LIN. On every clock edge each register takes the value computed from the one before it. A synchronous reset is the only other transition, and it returns all four registers to zero.

Top module: `rotor_round_pipe`

## Requirements
- R1: Stage 0 registers `rd_a + addend` modulo 2^16. The addend is `rd_b` when `add_fb` is 0, and the current `wb_data` (the stage 3 output) when `add_fb` is 1.
- R2: Stage 1 registers `stage0 ^ rd_b` when `mix_load` is 0, and `rd_a ^ rd_b` when `mix_load` is 1.
- R3: Stage 2 replaces each 4-bit nibble n of the stage 1 value with S[n]. The table is S = {7,C,E,9,2,1,5,F,B,6,D,0,4,8,A,3}, indexed 0 to F. No control bit affects this stage.
- R4: Stage 3 registers x ^ rotl(x,6) ^ rotl(x,10) when `lin_en` is 1, and x unchanged when `lin_en` is 0. Here x is the stage 2 value.
- R5: Every stage is registered. A word offered at the operand ports reaches `wb_data` on the fourth rising edge after it is presented. Each control bit acts only on its own stage in the cycle it is presented.
- R6: While `rst` is high at a rising edge, all four stage registers become zero. `wb_data` then reads 0x0000.
- R7: A carry out of bit 15 in stage 0 is discarded (for example, 0xFFFF + 0x0002 gives 0x0001).
- R8: With `add_fb` high, the feedback addend is the `wb_data` value present in that same cycle, before the edge that updates it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a | input | 16 | Register-file read port A |
| rd_b | input | 16 | Register-file read port B |
| add_fb | input | 1 | Stage 0 addend select: 0 = rd_b, 1 = wb_data feedback |
| mix_load | input | 1 | Stage 1 select: 0 = stage0 ^ rd_b, 1 = rd_a ^ rd_b |
| lin_en | input | 1 | Stage 3 select: 1 = rotate-XOR applied, 0 = bypass |
| wb_data | output | 16 | Stage 3 register, write-back data |

## Verification
The bench targets the adder wrap at 0xFFFF, where a design that kept the carry would corrupt the low bits. It drives every nibble value 0 to F through the substitution layer, so a single wrong table entry shows up at the output. It runs back-to-back feedback additions, where a design that added the stage 0 value or a stale output in place of the live `wb_data` would drift. It also asserts reset in the middle of a stream; a design that cleared only some stages would leak old words to the output in the cycles that follow. Control bits toggle on every cycle, so applying a bit to the wrong stage, or delaying it by one register, changes the expected results.

// File: rtl/rrp_pkg.sv
package rrp_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        ST_ADD = 2'd0,
        ST_MIX = 2'd1,
        ST_SUB = 2'd2,
        ST_LIN = 2'd3
    } stage_e;

    function automatic logic [NIB_W-1:0] sub_nib(input logic [NIB_W-1:0] n);
        logic [NIB_W-1:0] r;
        unique case (n)
            4'h0: r = 4'h7;
            4'h1: r = 4'hC;
            4'h2: r = 4'hE;
            4'h3: r = 4'h9;
            4'h4: r = 4'h2;
            4'h5: r = 4'h1;
            4'h6: r = 4'h5;
            4'h7: r = 4'hF;
            4'h8: r = 4'hB;
            4'h9: r = 4'h6;
            4'hA: r = 4'hD;
            4'hB: r = 4'h0;
            4'hC: r = 4'h4;
            4'hD: r = 4'h8;
            4'hE: r = 4'hA;
            default: r = 4'h3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rrp_add_stage.sv
module rrp_add_stage #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [WIDTH-1:0] fb,
    input  logic             use_fb,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] sum_c;

    always_comb begin
        addend = use_fb ? fb : opb;
        sum_c  = opa + addend;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= sum_c;
    end

    // R1
    add_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!use_fb && opb == '0) |=> (q == $past(opa)));

    // R7
    add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!use_fb && opa == '1 && opb == WIDTH'(2)) |=> (q == WIDTH'(1)));
endmodule

// File: rtl/rrp_xor_stage.sv
module rrp_xor_stage #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] prev,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             load,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] left_c;

    always_comb left_c = load ? opa : prev;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= left_c ^ opb;
    end

    // R2
    xor_self_chk: assert property (@(posedge clk) disable iff (rst)
        (load && opa == opb) |=> (q == '0));
endmodule

// File: rtl/rrp_sub_stage.sv
module rrp_sub_stage #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    import rrp_pkg::*;
    localparam int NIBS = WIDTH / NIB_W;

    logic [WIDTH-1:0] sub_c;

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        always_comb sub_c[g*NIB_W +: NIB_W] = sub_nib(d[g*NIB_W +: NIB_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= sub_c;
    end

    // R3
    sub_inject_chk: assert property (@(posedge clk) disable iff (rst)
        (d != $past(d)) |=> (q != $past(q)));
endmodule

// File: rtl/rrp_lin_stage.sv
module rrp_lin_stage #(
    parameter int WIDTH = 16,
    parameter int ROT_A = 6,
    parameter int ROT_B = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    input  logic             en,
    output logic [WIDTH-1:0] q
);
    localparam int BACK_A = WIDTH - ROT_A;
    localparam int BACK_B = WIDTH - ROT_B;

    logic [WIDTH-1:0] rot_a;
    logic [WIDTH-1:0] rot_b;
    logic [WIDTH-1:0] mix_c;

    always_comb begin
        rot_a = (d << ROT_A) | (d >> BACK_A);
        rot_b = (d << ROT_B) | (d >> BACK_B);
        mix_c = en ? (d ^ rot_a ^ rot_b) : d;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= mix_c;
    end

    // R4
    lin_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (q == $past(d)));

    // R4
    lin_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (en && d == '0) |=> (q == '0));
endmodule

// File: rtl/rotor_round_pipe.sv
module rotor_round_pipe #(
    parameter int WIDTH = 16,
    parameter int ROT_A = 6,
    parameter int ROT_B = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      rd_a,
    input  logic [15:0]      rd_b,
    input  logic             add_fb,
    input  logic             mix_load,
    input  logic             lin_en,
    output logic [15:0]      wb_data
);
    logic [WIDTH-1:0] add_q;
    logic [WIDTH-1:0] mix_q;
    logic [WIDTH-1:0] sub_q;
    logic [WIDTH-1:0] lin_q;

    rrp_add_stage #(.WIDTH(WIDTH)) u_add (
        .clk(clk), .rst(rst), .opa(rd_a), .opb(rd_b),
        .fb(lin_q), .use_fb(add_fb), .q(add_q)
    );

    rrp_xor_stage #(.WIDTH(WIDTH)) u_mix (
        .clk(clk), .rst(rst), .prev(add_q), .opa(rd_a), .opb(rd_b),
        .load(mix_load), .q(mix_q)
    );

    rrp_sub_stage #(.WIDTH(WIDTH)) u_sub (
        .clk(clk), .rst(rst), .d(mix_q), .q(sub_q)
    );

    rrp_lin_stage #(.WIDTH(WIDTH), .ROT_A(ROT_A), .ROT_B(ROT_B)) u_lin (
        .clk(clk), .rst(rst), .d(sub_q), .en(lin_en), .q(lin_q)
    );

    always_comb wb_data = lin_q;

    // R6
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (wb_data == '0 && add_q == '0 && mix_q == '0 && sub_q == '0));

    // R8
    fb_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (add_fb && rd_a == '0) |=> (add_q == $past(wb_data)));
endmodule

// File: tb/tb_rotor_round_pipe.sv
module tb_rotor_round_pipe;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rd_a = '0;
    logic [15:0] rd_b = '0;
    logic        add_fb = 1'b0;
    logic        mix_load = 1'b0;
    logic        lin_en = 1'b0;
    logic [15:0] wb_data;

    int vec_cnt = 0;
    int err_cnt = 0;
    logic [15:0] m0 = '0, m1 = '0, m2 = '0, m3 = '0;

    rotor_round_pipe dut (
        .clk(clk), .rst(rst), .rd_a(rd_a), .rd_b(rd_b), .add_fb(add_fb),
        .mix_load(mix_load), .lin_en(lin_en), .wb_data(wb_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] ref_sub(input logic [15:0] x);
        logic [3:0] tbl [16] = '{4'h7,4'hC,4'hE,4'h9,4'h2,4'h1,4'h5,4'hF,
                                 4'hB,4'h6,4'hD,4'h0,4'h4,4'h8,4'hA,4'h3};
        return {tbl[x[15:12]], tbl[x[11:8]], tbl[x[7:4]], tbl[x[3:0]]};
    endfunction

    function automatic logic [15:0] ref_lin(input logic [15:0] x);
        return x ^ {x[9:0], x[15:10]} ^ {x[5:0], x[15:6]};
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        vec_cnt++;
        if (wb_data !== exp) begin
            err_cnt++;
            $display("FAIL %s: wb_data=%h expected=%h", req, wb_data, exp);
        end
    endtask

    task automatic step(input logic r, input logic [15:0] a, input logic [15:0] b,
                        input logic c0, input logic c1, input logic c2, input string req);
        logic [15:0] n0, n1, n2, n3;
        @(negedge clk);
        rst = r; rd_a = a; rd_b = b; add_fb = c0; mix_load = c1; lin_en = c2;
        n0 = c0 ? 16'(a + m3) : 16'(a + b);
        n1 = c1 ? (a ^ b) : (m0 ^ b);
        n2 = ref_sub(m1);
        n3 = c2 ? ref_lin(m2) : m2;
        if (r) begin n0 = '0; n1 = '0; n2 = '0; n3 = '0; end
        @(posedge clk);
        m0 = n0; m1 = n1; m2 = n2; m3 = n3;
        #1;
        check(req, m3);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) step(1'b1, 16'hABCD, 16'h1234, 1'b1, 1'b1, 1'b1, "R6");
        check("R6", 16'h0000);
    endtask

    task automatic t_latency();
        step(1'b0, 16'h1357, 16'h0000, 1'b0, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 3; i++) step(1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, "R5");
        check("R5", ref_sub(16'h1357));
        for (int i = 0; i < 3; i++) step(1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_wrap();
        step(1'b0, 16'hFFFF, 16'h0002, 1'b0, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 3; i++) step(1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, "R7");
        check("R7", ref_sub(16'h0001));
    endtask

    task automatic t_sbox();
        for (int n = 0; n < 16; n++)
            step(1'b0, {4{4'(n)}}, 16'h0000, 1'b0, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 3; i++) step(1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_xor();
        for (int i = 0; i < 12; i++)
            step(1'b0, 16'(16'h2F1B * i + 7), 16'(16'h9A35 ^ (i * 16'h0111)),
                 1'b0, 1'(i % 2), 1'b0, "R2");
    endtask

    task automatic t_lin();
        for (int i = 0; i < 12; i++)
            step(1'b0, 16'(16'h4C1D * i), 16'(16'h0F0F + i), 1'b0, 1'(i % 3 == 0),
                 1'(i % 2), "R4");
    endtask

    task automatic t_feedback();
        for (int i = 0; i < 16; i++)
            step(1'b0, 16'(16'h0101 * i), 16'hBEEF, 1'b1, 1'(i % 4 == 1), 1'b1, "R8");
        for (int i = 0; i < 8; i++)
            step(1'b0, 16'(16'h7777 + i), 16'(16'h1111 * i), 1'(i % 2), 1'b0, 1'b1, "R1");
    endtask

    task automatic t_mid_reset();
        for (int i = 0; i < 3; i++) step(1'b0, 16'hCAFE, 16'h0F0F, 1'b0, 1'b0, 1'b1, "R6");
        step(1'b1, 16'hCAFE, 16'h0F0F, 1'b0, 1'b0, 1'b1, "R6");
        check("R6", 16'h0000);
        for (int i = 0; i < 4; i++) step(1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, "R6");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_wrap();
        t_sbox();
        t_xor();
        t_lin();
        t_feedback();
        t_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        err_cnt++;
        $display("FAIL watchdog: wb_data=%h expected=finish", wb_data);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end
endmodule